// File: doc/BRIEF.md
# Dual-Form LFSR Pattern Generator

This block produces pseudo-random test patterns for a logic self-test. It holds an n-bit shift register whose next value is fixed by one coefficient vector: bit i of `COEF` is the coefficient of x^i in the characteristic polynomial f(x) = 1 + h1·x + … + h(n−1)·x^(n−1) + x^n. The term x^n is implied, and bit 0 stands for the constant term. The parameter `MODULAR` picks how that polynomial is wired. With `MODULAR = 0` a single XOR tree across the tapped stages feeds the top stage. With `MODULAR = 1` there is an XOR gate in front of each tapped stage, and the top stage feeds back straight into stage 0. A primitive polynomial gives the same period, 2^n − 1, in either form.

A seed can be loaded at any time. The block never holds the all-zero state, which would lock it. A one-cycle flag marks each return to the loaded seed, so a controller can count one full pass of patterns. Each cycle the control decides between three actions: LOAD (seed strobe high, which wins over everything else), STEP (enable high, no strobe) and HOLD (neither). LOAD goes back to LOAD, STEP or HOLD on the next cycle according to the inputs, and the same holds for STEP and HOLD. Reset puts the block into HOLD with the reset pattern.

Top module: `lfsr_patgen`

## Requirements
- R1: Reset is asynchronous and active low. While it is applied, and after it is released until the first action, `pattern_o` equals 1 (only bit 0 set) and `period_o` is 0.
- R2: With `MODULAR = 0`, each STEP moves stage i+1 into stage i for i < n−1. Stage n−1 receives the XOR of every stage i whose `COEF[i]` is 1, and `COEF[0]` must be 1.
- R3: With `MODULAR = 1`, each STEP moves stage n−1 into stage 0. Every other stage i receives stage i−1, XORed with stage n−1 when `COEF[i]` is 1.
- R4: In HOLD (`en_i` low, `seed_load_i` low), `pattern_o` keeps its value and `period_o` is 0.
- R5: LOAD puts `seed_i` into `pattern_o` on the next edge, whatever `en_i` is, and makes `period_o` 0 on that edge.
- R6: Loading an all-zero seed gives the value 1 instead, and that value also becomes the stored reference for R7.
- R7: `period_o` is 1 in exactly those cycles where a STEP has just moved `pattern_o` back to the last loaded seed. For a primitive polynomial this happens 2^n − 1 steps after the load.
- R8: `pattern_o` is never all zero.
- R9: For n = 3, the standard form and COEF = 3'b011 (f = 1 + x + x^3), starting from seed 3'b001, the values are 1, 4, 2, 5, 6, 7, 3 and then 1 again, with `period_o` high on that return.
- R10: Over one full period of a primitive 8-bit register, the bit-0 stream, taken circularly, has exactly one run of 8 ones and one run of 7 zeros, and no longer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance one step per cycle |
| seed_load_i | input | 1 | Load `seed_i`; has priority over `en_i` |
| seed_i | input | WIDTH | Seed value; zero is replaced by 1 |
| pattern_o | output | WIDTH | Current pattern, bit i = stage Xi |
| period_o | output | 1 | Pulse on return to the loaded seed |

## Verification
Both `pattern_o` and `period_o` come straight from registers, so each result appears at the first rising edge after the inputs that cause it. The bench changes inputs on falling edges and reads outputs on the next falling edge, which is exactly one action later. Period checks count steps from the cycle after the load and expect the flag only on step 2^n − 1, with no pulse at any earlier step.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_LOAD = 2'd2
    } lfsr_act_e;
endpackage

// File: rtl/lfsr_step.sv
module lfsr_step #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    COEF    = 8'b0001_1101,
    parameter bit              MODULAR = 1'b1
) (
    input  logic [W-1:0] cur_i,
    output logic [W-1:0] nxt_o
);
    generate
        if (!MODULAR) begin : g_std
            // external XOR tree feeds the top stage, others shift down
            assign nxt_o[W-2:0] = cur_i[W-1:1];
            assign nxt_o[W-1]   = ^(cur_i & COEF);
        end else begin : g_mod
            // top stage wraps into stage 0, XOR gates sit before tapped stages
            assign nxt_o[0] = cur_i[W-1];
            for (genvar i = 1; i < W; i++) begin : g_bit
                if (COEF[i]) begin : g_tap
                    assign nxt_o[i] = cur_i[i-1] ^ cur_i[W-1];
                end else begin : g_wire
                    assign nxt_o[i] = cur_i[i-1];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/lfsr_period.sv
module lfsr_period
    import lfsr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  lfsr_act_e    act_i,
    input  logic [W-1:0] seed_i,
    input  logic [W-1:0] nxt_i,
    output logic         wrap_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] ref_q;
    logic         wrap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_q  <= ONE;
            wrap_q <= 1'b0;
        end else begin
            unique case (act_i)
                ACT_LOAD: begin
                    ref_q  <= seed_i;
                    wrap_q <= 1'b0;
                end
                ACT_STEP: wrap_q <= (nxt_i == ref_q);
                default:  wrap_q <= 1'b0;
            endcase
        end
    end

    assign wrap_o = wrap_q;

    // R7: a pulse only follows a step
    p_wrap_after_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wrap_q |-> $past(act_i) == ACT_STEP);
endmodule

// File: rtl/lfsr_patgen.sv
module lfsr_patgen
    import lfsr_pkg::*;
#(
    parameter int                WIDTH   = 8,
    parameter logic [WIDTH-1:0]  COEF    = 8'b0001_1101,
    parameter bit                MODULAR = 1'b1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             seed_load_i,
    input  logic [WIDTH-1:0] seed_i,
    output logic [WIDTH-1:0] pattern_o,
    output logic             period_o
);
    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    lfsr_act_e        act;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_nxt;
    logic [WIDTH-1:0] seed_eff;

    // action decode: load wins over enable
    always_comb begin
        if (seed_load_i)  act = ACT_LOAD;
        else if (en_i)    act = ACT_STEP;
        else              act = ACT_HOLD;
    end

    assign seed_eff = (seed_i == '0) ? ONE : seed_i;

    lfsr_step #(
        .W       (WIDTH),
        .COEF    (COEF),
        .MODULAR (MODULAR)
    ) u_step (
        .cur_i (state_q),
        .nxt_o (state_nxt)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ONE;
        end else begin
            unique case (act)
                ACT_LOAD: state_q <= seed_eff;
                ACT_STEP: state_q <= state_nxt;
                default:  state_q <= state_q;
            endcase
        end
    end

    lfsr_period #(.W(WIDTH)) u_period (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .act_i  (act),
        .seed_i (seed_eff),
        .nxt_i  (state_nxt),
        .wrap_o (period_o)
    );

    assign pattern_o = state_q;

    // R8: lock-up state never reached
    p_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pattern_o != '0);
    // R4: hold keeps the pattern
    p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !seed_load_i) |=> $stable(pattern_o) && !period_o);
    // R5: non-zero seed appears next cycle
    p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seed_load_i && seed_i != '0) |=> pattern_o == $past(seed_i));
    // R6: zero seed becomes one
    p_zero_seed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seed_load_i && seed_i == '0) |=> pattern_o == ONE);

    generate
        if (!MODULAR) begin : g_chk_std
            // R2: stages shift toward X0
            p_shift_std_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_i && !seed_load_i) |=>
                    pattern_o[WIDTH-2:0] == $past(pattern_o[WIDTH-1:1]));
        end else begin : g_chk_mod
            // R3: top stage wraps into X0
            p_wrap_mod_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (en_i && !seed_load_i) |=> pattern_o[0] == $past(pattern_o[WIDTH-1]));
        end
    endgenerate
endmodule

// File: tb/lfsr_patgen_tb.sv
module lfsr_patgen_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // u_dut: 8-bit modular, f = 1 + x^2 + x^3 + x^4 + x^8
    logic       en_m, ld_m;
    logic [7:0] sd_m, pat_m;
    logic       per_m;
    // 8-bit standard, same polynomial
    logic       en_s, ld_s;
    logic [7:0] sd_s, pat_s;
    logic       per_s;
    // 3-bit standard, f = 1 + x + x^3
    logic       en_3, ld_3;
    logic [2:0] sd_3, pat_3;
    logic       per_3;
    // 8-bit modular, f = 1 + x^2 + x^7 + x^8
    logic       en_d, ld_d;
    logic [7:0] sd_d, pat_d;
    logic       per_d;

    localparam logic [7:0] C_PRIM = 8'b0001_1101;
    localparam logic [7:0] C_DOC  = 8'b1000_0101;

    lfsr_patgen u_dut (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_m), .seed_load_i(ld_m),
        .seed_i(sd_m), .pattern_o(pat_m), .period_o(per_m));

    lfsr_patgen #(.WIDTH(8), .COEF(C_PRIM), .MODULAR(1'b0)) u_dut_std8 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_s), .seed_load_i(ld_s),
        .seed_i(sd_s), .pattern_o(pat_s), .period_o(per_s));

    lfsr_patgen #(.WIDTH(3), .COEF(3'b011), .MODULAR(1'b0)) u_dut_std3 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_3), .seed_load_i(ld_3),
        .seed_i(sd_3), .pattern_o(pat_3), .period_o(per_3));

    lfsr_patgen #(.WIDTH(8), .COEF(C_DOC), .MODULAR(1'b1)) u_dut_mod8 (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en_d), .seed_load_i(ld_d),
        .seed_i(sd_d), .pattern_o(pat_d), .period_o(per_d));

    function automatic logic [7:0] f_std(input logic [7:0] s, input logic [7:0] c);
        return {^(s & c), s[7:1]};
    endfunction

    function automatic logic [7:0] f_mod(input logic [7:0] s, input logic [7:0] c);
        logic [7:0] r;
        r[0] = s[7];
        for (int i = 1; i < 8; i++) r[i] = s[i-1] ^ (c[i] & s[7]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_all();
        en_m = 0; ld_m = 0; sd_m = 0;
        en_s = 0; ld_s = 0; sd_s = 0;
        en_3 = 0; ld_3 = 0; sd_3 = 0;
        en_d = 0; ld_d = 0; sd_d = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 pattern in reset", pat_m, 8'h01);
        chk("R1 flag in reset", per_m, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pattern after release", pat_s, 8'h01);
        chk("R1 3-bit after release", pat_3, 3'd1);
        chk("R1 flag after release", per_s, 0);
    endtask

    task automatic t_seq3();
        logic [2:0] exp_seq [7] = '{3'd4, 3'd2, 3'd5, 3'd6, 3'd7, 3'd3, 3'd1};
        @(negedge clk); ld_3 = 1; sd_3 = 3'd1;
        @(negedge clk); ld_3 = 0; en_3 = 1;
        chk("R9 seed loaded", pat_3, 3'd1);
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk("R9 sequence", pat_3, exp_seq[k]);
            chk("R9 flag", per_3, (k == 6));
        end
        en_3 = 0;
    endtask

    task automatic t_hold();
        logic [7:0] v;
        @(negedge clk); ld_m = 1; sd_m = 8'hA5;
        @(negedge clk); ld_m = 0; en_m = 1;
        chk("R5 load value", pat_m, 8'hA5);
        @(negedge clk); en_m = 0;
        v = pat_m;
        chk("R3 one step", pat_m, f_mod(8'hA5, C_PRIM));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R4 held pattern", pat_m, v);
            chk("R4 flag low", per_m, 0);
        end
    endtask

    task automatic t_load_priority();
        @(negedge clk); ld_m = 1; en_m = 1; sd_m = 8'h3C;
        @(negedge clk); ld_m = 0; en_m = 0;
        chk("R5 load beats enable", pat_m, 8'h3C);
        chk("R5 flag after load", per_m, 0);
        @(negedge clk); ld_m = 1; sd_m = 8'h00;
        @(negedge clk); ld_m = 0;
        chk("R6 zero seed becomes one", pat_m, 8'h01);
        chk("R8 non-zero", (pat_m != 0), 1);
    endtask

    task automatic t_period_mod();
        logic [7:0] m;
        int first;
        @(negedge clk); ld_m = 1; sd_m = 8'h00;
        @(negedge clk); ld_m = 0; en_m = 1;
        m = 8'h01; first = 0;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            m = f_mod(m, C_PRIM);
            if (pat_m !== m) chk("R3 modular step", pat_m, m);
            if (per_m && first == 0) first = k;
        end
        chk("R7 modular period (zero seed -> R6 reference)", first, 255);
        chk("R7 pattern back at seed", pat_m, 8'h01);
        @(negedge clk); en_m = 0;
        chk("R7 flag one cycle", per_m, 0);
    endtask

    task automatic t_period_std_runs();
        logic [7:0]   m;
        logic [254:0] bits;
        int first, max1, max0, n1, n0;
        @(negedge clk); ld_s = 1; sd_s = 8'h5B;
        @(negedge clk); ld_s = 0; en_s = 1;
        m = 8'h5B; first = 0;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            m = f_std(m, C_PRIM);
            if (pat_s !== m) chk("R2 standard step", pat_s, m);
            bits[k-1] = pat_s[0];
            if (per_s && first == 0) first = k;
        end
        en_s = 0;
        chk("R7 standard period", first, 255);
        max1 = 0; max0 = 0; n1 = 0; n0 = 0;
        for (int i = 0; i < 255; i++) begin
            int len;
            if (bits[i] != bits[(i + 254) % 255]) begin
                len = 0;
                while (len < 255 && bits[(i + len) % 255] == bits[i]) len++;
                if (bits[i]) begin
                    if (len > max1) max1 = len;
                    if (len == 8) n1++;
                end else begin
                    if (len > max0) max0 = len;
                    if (len == 7) n0++;
                end
            end
        end
        chk("R10 longest ones run", max1, 8);
        chk("R10 one run of eight ones", n1, 1);
        chk("R10 longest zeros run", max0, 7);
        chk("R10 one run of seven zeros", n0, 1);
    endtask

    task automatic t_doc_mod8();
        logic [7:0] m;
        @(negedge clk); ld_d = 1; sd_d = 8'h80;
        @(negedge clk); ld_d = 0; en_d = 1;
        m = 8'h80;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            m = f_mod(m, C_DOC);
            chk("R3 modular taps 2 and 7", pat_d, m);
        end
        en_d = 0;
    endtask

    initial begin
        idle_all();
        t_reset();
        t_seq3();
        t_hold();
        t_load_priority();
        t_period_mod();
        t_period_std_runs();
        t_doc_mod8();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule